// File: doc/BRIEF.md
# Radix-3 Final-Pass Combining Engine

This block performs the closing radix-3 butterfly of a length-N transform with N = 3M. The long input block has already been split into three interleaved sub-blocks, and each of them has been transformed by its own engine. On every accepted beat this block takes bin k of all three sub-results (Y0[k], Y1[k], Y2[k]) together with the twiddles W^k and W^2k. It returns three finished output bins at once, one per lane. Lane 0 carries X[k], lane 1 carries X[k+M] and lane 2 carries X[k+2M]. Feeding k = 0..M-1 in order therefore makes lane q stream out the q-th contiguous third of the spectrum.

All samples are 16-bit signed I/Q values in Q1.15. The engine first forms the products Z1 = W^k·Y1 and Z2 = W^2k·Y2. It then rotates them with the radix-3 roots of unity. A build-time parameter selects the conjugate rotation for the inverse transform, and in that mode no 1/N scaling is applied. Start-of-packet and end-of-packet markers ride through the engine alongside their beat.

Both data edges use valid/ready. A beat moves on the input when `in_valid` and `in_ready` are both high on a rising edge, and on the output when `out_valid` and `out_ready` are both high. The pipeline stalls as a whole. While the output holds a beat that is not taken, nothing advances, the output stays frozen and `in_ready` is low. When the output is empty or is being taken, the engine accepts a new beat in the same cycle.

Top module: `r3c_engine`

## Requirements
- R1: After reset, and until a beat has been accepted, `out_valid` is low and `in_ready` is high.
- R2: The pipeline has four register stages. With `out_ready` held high, a beat accepted on rising edge P0 appears on the outputs just after the third rising edge after P0, so the fourth falling edge counted from P0 is the first one at which `out_valid` is seen high.
- R3: Lane 0 outputs sat(Y0 + Z1 + Z2) on each of I and Q. Here sat clamps to the range -32768..32767.
- R4: Z1 and Z2 are rounded Q1.15 complex products. For example Z1.re = sat((Y1.re·W1.re − Y1.im·W1.im + 16384) >> 15) and Z1.im = sat((Y1.re·W1.im + Y1.im·W1.re + 16384) >> 15), where >> is an arithmetic shift. Z2 is formed the same way from Y2 and W2.
- R5: In forward mode (INVERSE = 0), let A = Z1 + Z2 and D = Z1 − Z2, both kept exact. Let P = (−16384·A + 16384) >> 15 and Q = (28378·D + 16384) >> 15, each taken per component. Lane 1 is then (sat(Y0.re + P.re + Q.im), sat(Y0.im + P.im − Q.re)) and lane 2 is (sat(Y0.re + P.re − Q.im), sat(Y0.im + P.im + Q.re)).
- R6: In inverse mode (INVERSE = 1), lane 1 takes the forward lane-2 expression and lane 2 takes the forward lane-1 expression. Lane 0 is unchanged and no scaling by 1/N is applied.
- R7: `out_sop` and `out_eop` equal the `in_sop` and `in_eop` that were given with the same beat, and they are high only while `out_valid` is high.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and on the next cycle the output beat, including its markers, is unchanged.
- R9: Output beats come out in acceptance order with none lost or duplicated, and at most four beats are in flight.
- R10: Full-scale inputs saturate rather than wrap. A (−32768)·(−32768) product gives +32767, and a lane sum beyond the range clamps to +32767 or −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Engine can take a beat this cycle |
| in_sop | input | 1 | First beat of a transform |
| in_eop | input | 1 | Last beat of a transform |
| in_y0_re | input | 16 | Sub-result 0, bin k, I |
| in_y0_im | input | 16 | Sub-result 0, bin k, Q |
| in_y1_re | input | 16 | Sub-result 1, bin k, I |
| in_y1_im | input | 16 | Sub-result 1, bin k, Q |
| in_y2_re | input | 16 | Sub-result 2, bin k, I |
| in_y2_im | input | 16 | Sub-result 2, bin k, Q |
| in_w1_re | input | 16 | Twiddle W^k, I, Q1.15 |
| in_w1_im | input | 16 | Twiddle W^k, Q, Q1.15 |
| in_w2_re | input | 16 | Twiddle W^2k, I, Q1.15 |
| in_w2_im | input | 16 | Twiddle W^2k, Q, Q1.15 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_sop | output | 1 | Marker of the first beat |
| out_eop | output | 1 | Marker of the last beat |
| out_x0_re | output | 16 | Lane 0 (bin k), I |
| out_x0_im | output | 16 | Lane 0 (bin k), Q |
| out_x1_re | output | 16 | Lane 1 (bin k+M), I |
| out_x1_im | output | 16 | Lane 1 (bin k+M), Q |
| out_x2_re | output | 16 | Lane 2 (bin k+2M), I |
| out_x2_im | output | 16 | Lane 2 (bin k+2M), Q |

## Verification
The assertions assume that `in_valid` is only sampled after reset is released and that `out_ready` may change freely, even while a beat is held. They check hold-while-stalled, marker qualification and in-flight bounds without regard to data values. The stimulus meets these assumptions by driving every input on the falling edge only after reset has been released. It toggles `in_valid` and `out_ready` at random rates so that stalls of every length occur, and it mixes arbitrary 16-bit operands with full-scale corner values so that both rounding and saturation are reached. Two engines, one per mode, see identical stimulus, and each is compared against its own expected queue.

// File: rtl/r3c_pkg.sv
package r3c_pkg;
  parameter int unsigned IQ_W = 16;
  localparam int unsigned FRAC = IQ_W - 1;
  localparam int unsigned ACC_W = 2 * IQ_W + 4;
  localparam int unsigned CMUL_STAGES = 1;
  localparam int unsigned FOLD_STAGES = 3;
  localparam int unsigned PIPE_STAGES = CMUL_STAGES + FOLD_STAGES;
  localparam int unsigned TAG_W = 2;

  typedef logic signed [IQ_W-1:0]  iq_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef struct packed {
    iq_t re;
    iq_t im;
  } cplx_t;

  typedef struct packed {
    acc_t re;
    acc_t im;
  } wide_t;

  localparam acc_t HALF_LSB = acc_t'(1) <<< (FRAC - 1);
  localparam acc_t NEG_HALF = -(acc_t'(1) <<< (FRAC - 1));
  localparam acc_t SQ3_HALF = acc_t'($rtoi(0.8660254037844386 * (2.0 ** FRAC) + 0.5));
  localparam acc_t IQ_MAX   = (acc_t'(1) <<< (IQ_W - 1)) - acc_t'(1);
  localparam acc_t IQ_MIN   = -(acc_t'(1) <<< (IQ_W - 1));

  function automatic acc_t rnd(input acc_t x);
    return (x + HALF_LSB) >>> FRAC;
  endfunction

  function automatic iq_t sat(input acc_t x);
    if (x > IQ_MAX) return iq_t'(IQ_MAX);
    if (x < IQ_MIN) return iq_t'(IQ_MIN);
    return iq_t'(x);
  endfunction

  function automatic acc_t widen(input iq_t x);
    return acc_t'(x);
  endfunction
endpackage

// File: rtl/r3c_cmul.sv
module r3c_cmul
  import r3c_pkg::*;
(
  input  logic  clk,
  input  logic  adv,
  input  cplx_t a,
  input  cplx_t b,
  output cplx_t p
);
  acc_t prod_re;
  acc_t prod_im;

  always_comb begin
    prod_re = widen(a.re) * widen(b.re) - widen(a.im) * widen(b.im);
    prod_im = widen(a.re) * widen(b.im) + widen(a.im) * widen(b.re);
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      p.re <= sat(rnd(prod_re));
      p.im <= sat(rnd(prod_im));
    end
  end
endmodule

// File: rtl/r3c_fold.sv
module r3c_fold
  import r3c_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic  clk,
  input  logic  adv,
  input  cplx_t y0,
  input  cplx_t z1,
  input  cplx_t z2,
  output cplx_t x0,
  output cplx_t x1,
  output cplx_t x2
);
  // stage A: sum and difference of the rotated sub-results
  cplx_t y0_a;
  wide_t sum_a;
  wide_t dif_a;

  always_ff @(posedge clk) begin
    if (adv) begin
      y0_a     <= y0;
      sum_a.re <= widen(z1.re) + widen(z2.re);
      sum_a.im <= widen(z1.im) + widen(z2.im);
      dif_a.re <= widen(z1.re) - widen(z2.re);
      dif_a.im <= widen(z1.im) - widen(z2.im);
    end
  end

  // stage B: lane 0 final, constant scaling of sum and difference
  cplx_t y0_b;
  cplx_t x0_b;
  wide_t half_b;
  wide_t root_b;

  always_ff @(posedge clk) begin
    if (adv) begin
      y0_b      <= y0_a;
      x0_b.re   <= sat(widen(y0_a.re) + sum_a.re);
      x0_b.im   <= sat(widen(y0_a.im) + sum_a.im);
      half_b.re <= rnd(sum_a.re * NEG_HALF);
      half_b.im <= rnd(sum_a.im * NEG_HALF);
      root_b.re <= rnd(dif_a.re * SQ3_HALF);
      root_b.im <= rnd(dif_a.im * SQ3_HALF);
    end
  end

  // stage C: combine with -j (lane "minus") or +j (lane "plus") rotation
  acc_t base_re;
  acc_t base_im;
  cplx_t minus_c;
  cplx_t plus_c;

  always_comb begin
    base_re    = widen(y0_b.re) + half_b.re;
    base_im    = widen(y0_b.im) + half_b.im;
    minus_c.re = sat(base_re + root_b.im);
    minus_c.im = sat(base_im - root_b.re);
    plus_c.re  = sat(base_re - root_b.im);
    plus_c.im  = sat(base_im + root_b.re);
  end

  cplx_t lane1_sel;
  cplx_t lane2_sel;

  generate
    if (INVERSE) begin : g_inv
      assign lane1_sel = plus_c;
      assign lane2_sel = minus_c;
    end else begin : g_fwd
      assign lane1_sel = minus_c;
      assign lane2_sel = plus_c;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (adv) begin
      x0 <= x0_b;
      x1 <= lane1_sel;
      x2 <= lane2_sel;
    end
  end
endmodule

// File: rtl/r3c_tagpipe.sv
module r3c_tagpipe #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_vld,
  input  logic [TW-1:0] in_tag,
  output logic          out_vld,
  output logic [TW-1:0] out_tag
);
  logic [DEPTH-1:0] vld;
  logic [TW-1:0]    tag [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic          nxt_vld;
      logic [TW-1:0] nxt_tag;
      if (s == 0) begin : g_head
        assign nxt_vld = in_vld;
        assign nxt_tag = in_tag;
      end else begin : g_body
        assign nxt_vld = vld[s-1];
        assign nxt_tag = tag[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[s] <= 1'b0;
          tag[s] <= '0;
        end else if (adv) begin
          vld[s] <= nxt_vld;
          tag[s] <= nxt_vld ? nxt_tag : '0;
        end
      end
    end
  endgenerate

  assign out_vld = vld[DEPTH-1];
  assign out_tag = tag[DEPTH-1];
endmodule

// File: rtl/r3c_engine.sv
module r3c_engine
  import r3c_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_sop,
  input  logic                   in_eop,
  input  logic signed [IQ_W-1:0] in_y0_re,
  input  logic signed [IQ_W-1:0] in_y0_im,
  input  logic signed [IQ_W-1:0] in_y1_re,
  input  logic signed [IQ_W-1:0] in_y1_im,
  input  logic signed [IQ_W-1:0] in_y2_re,
  input  logic signed [IQ_W-1:0] in_y2_im,
  input  logic signed [IQ_W-1:0] in_w1_re,
  input  logic signed [IQ_W-1:0] in_w1_im,
  input  logic signed [IQ_W-1:0] in_w2_re,
  input  logic signed [IQ_W-1:0] in_w2_im,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_sop,
  output logic                   out_eop,
  output logic signed [IQ_W-1:0] out_x0_re,
  output logic signed [IQ_W-1:0] out_x0_im,
  output logic signed [IQ_W-1:0] out_x1_re,
  output logic signed [IQ_W-1:0] out_x1_im,
  output logic signed [IQ_W-1:0] out_x2_re,
  output logic signed [IQ_W-1:0] out_x2_im
);
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  cplx_t y0_in;
  cplx_t src_y [2];
  cplx_t src_w [2];
  cplx_t rot   [2];

  assign y0_in    = '{re: in_y0_re, im: in_y0_im};
  assign src_y[0] = '{re: in_y1_re, im: in_y1_im};
  assign src_y[1] = '{re: in_y2_re, im: in_y2_im};
  assign src_w[0] = '{re: in_w1_re, im: in_w1_im};
  assign src_w[1] = '{re: in_w2_re, im: in_w2_im};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_twid
      r3c_cmul u_mul (
        .clk (clk),
        .adv (adv),
        .a   (src_y[g]),
        .b   (src_w[g]),
        .p   (rot[g])
      );
    end
  endgenerate

  cplx_t y0_d;
  always_ff @(posedge clk) begin
    if (adv) y0_d <= y0_in;
  end

  cplx_t x0;
  cplx_t x1;
  cplx_t x2;

  r3c_fold #(.INVERSE(INVERSE)) u_fold (
    .clk (clk),
    .adv (adv),
    .y0  (y0_d),
    .z1  (rot[0]),
    .z2  (rot[1]),
    .x0  (x0),
    .x1  (x1),
    .x2  (x2)
  );

  logic [TAG_W-1:0] tag_out;

  r3c_tagpipe #(.DEPTH(PIPE_STAGES), .TW(TAG_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .in_vld  (in_valid),
    .in_tag  ({in_sop, in_eop}),
    .out_vld (out_valid),
    .out_tag (tag_out)
  );

  assign out_sop   = tag_out[1];
  assign out_eop   = tag_out[0];
  assign out_x0_re = x0.re;
  assign out_x0_im = x0.im;
  assign out_x1_re = x1.re;
  assign out_x1_im = x1.im;
  assign out_x2_re = x2.re;
  assign out_x2_im = x2.im;
endmodule

// File: rtl/r3c_engine_chk.sv
module r3c_engine_chk
  import r3c_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_sop,
  input logic            out_eop,
  input logic [IQ_W-1:0] out_x0_re,
  input logic [IQ_W-1:0] out_x0_im,
  input logic [IQ_W-1:0] out_x1_re,
  input logic [IQ_W-1:0] out_x1_im,
  input logic [IQ_W-1:0] out_x2_re,
  input logic [IQ_W-1:0] out_x2_im
);
  logic [6*IQ_W+1:0] beat;
  assign beat = {out_sop, out_eop, out_x0_re, out_x0_im,
                 out_x1_re, out_x1_im, out_x2_re, out_x2_im};

  logic [7:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      assert_inflight_R9: assert (inflight <= 8'(PIPE_STAGES));
    end
  end

  assert_deliver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 8'd0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(beat)));

  assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == 8'd0) |-> !out_valid);
endmodule

bind r3c_engine r3c_engine_chk u_chk (.*);

// File: tb/test_r3c_engine.sv
module test_r3c_engine;
  localparam int PKT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b0;
  logic signed [15:0] y0r = 0, y0i = 0, y1r = 0, y1i = 0, y2r = 0, y2i = 0;
  logic signed [15:0] w1r = 0, w1i = 0, w2r = 0, w2i = 0;

  logic in_ready, out_valid, out_sop, out_eop;
  logic signed [15:0] f0r, f0i, f1r, f1i, f2r, f2i;
  logic in_ready_i, out_valid_i, out_sop_i, out_eop_i;
  logic signed [15:0] v0r, v0i, v1r, v1i, v2r, v2i;

  r3c_engine #(.INVERSE(1'b0)) i_r3c_engine (
    .clk, .rst_n, .in_valid, .in_ready, .in_sop, .in_eop,
    .in_y0_re(y0r), .in_y0_im(y0i), .in_y1_re(y1r), .in_y1_im(y1i),
    .in_y2_re(y2r), .in_y2_im(y2i), .in_w1_re(w1r), .in_w1_im(w1i),
    .in_w2_re(w2r), .in_w2_im(w2i),
    .out_valid, .out_ready, .out_sop, .out_eop,
    .out_x0_re(f0r), .out_x0_im(f0i), .out_x1_re(f1r), .out_x1_im(f1i),
    .out_x2_re(f2r), .out_x2_im(f2i));

  r3c_engine #(.INVERSE(1'b1)) i_r3c_engine_inv (
    .clk, .rst_n, .in_valid, .in_ready(in_ready_i), .in_sop, .in_eop,
    .in_y0_re(y0r), .in_y0_im(y0i), .in_y1_re(y1r), .in_y1_im(y1i),
    .in_y2_re(y2r), .in_y2_im(y2i), .in_w1_re(w1r), .in_w1_im(w1i),
    .in_w2_re(w2r), .in_w2_im(w2i),
    .out_valid(out_valid_i), .out_ready, .out_sop(out_sop_i), .out_eop(out_eop_i),
    .out_x0_re(v0r), .out_x0_im(v0i), .out_x1_re(v1r), .out_x1_im(v1i),
    .out_x2_re(v2r), .out_x2_im(v2i));

  typedef struct {
    longint x [6];
    bit sop;
    bit eop;
  } exp_t;

  exp_t qf[$];
  exp_t qi[$];
  int checks = 0;
  int fails = 0;
  int beat_cnt = 0;
  bit prev_stall = 0;
  longint snap [6];
  bit snap_sop, snap_eop;
  longint last_f [6];

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint rnd(input longint x);
    return (x + 16384) >>> 15;
  endfunction

  function automatic longint sat(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic exp_t model(input bit inv);
    exp_t e;
    longint z1r, z1i, z2r, z2i, ar, ai, dr, di, pr, pi, qr, qi2, br, bi, s;
    z1r = sat(rnd(longint'(y1r) * w1r - longint'(y1i) * w1i));
    z1i = sat(rnd(longint'(y1r) * w1i + longint'(y1i) * w1r));
    z2r = sat(rnd(longint'(y2r) * w2r - longint'(y2i) * w2i));
    z2i = sat(rnd(longint'(y2r) * w2i + longint'(y2i) * w2r));
    ar = z1r + z2r; ai = z1i + z2i;
    dr = z1r - z2r; di = z1i - z2i;
    pr = rnd(-16384 * ar); pi = rnd(-16384 * ai);
    qr = rnd(28378 * dr);  qi2 = rnd(28378 * di);
    br = longint'(y0r) + pr; bi = longint'(y0i) + pi;
    s = inv ? -1 : 1;
    e.x[0] = sat(longint'(y0r) + ar);
    e.x[1] = sat(longint'(y0i) + ai);
    e.x[2] = sat(br + s * qi2);
    e.x[3] = sat(bi - s * qr);
    e.x[4] = sat(br - s * qi2);
    e.x[5] = sat(bi + s * qr);
    e.sop = in_sop;
    e.eop = in_eop;
    return e;
  endfunction

  function automatic logic signed [15:0] r16();
    return 16'($urandom);
  endfunction

  // evaluate handshakes that the next rising edge will perform, then step
  task automatic tick();
    exp_t e;
    #1;
    if (prev_stall) begin
      chk("R8 held lane0 re", f0r, snap[0]);
      chk("R8 held lane2 im", f2i, snap[5]);
      chk("R8 held sop", out_sop, snap_sop);
      chk("R8 held eop", out_eop, snap_eop);
    end
    prev_stall = out_valid && !out_ready;
    if (prev_stall) begin
      chk("R8 in_ready low while stalled", in_ready, 0);
      snap = '{f0r, f0i, f1r, f1i, f2r, f2i};
      snap_sop = out_sop;
      snap_eop = out_eop;
    end
    if (out_valid && out_ready) begin
      if (qf.size() == 0) chk("R9 unexpected forward beat", 1, 0);
      else begin
        e = qf.pop_front();
        chk("R3 lane0 re", f0r, e.x[0]);
        chk("R3 lane0 im", f0i, e.x[1]);
        chk("R5 lane1 re", f1r, e.x[2]);
        chk("R5 lane1 im", f1i, e.x[3]);
        chk("R5 lane2 re", f2r, e.x[4]);
        chk("R5 lane2 im", f2i, e.x[5]);
        chk("R7 sop", out_sop, e.sop);
        chk("R7 eop", out_eop, e.eop);
      end
      last_f = '{f0r, f0i, f1r, f1i, f2r, f2i};
    end
    if (out_valid_i && out_ready) begin
      if (qi.size() == 0) chk("R9 unexpected inverse beat", 1, 0);
      else begin
        e = qi.pop_front();
        chk("R6 lane0 re", v0r, e.x[0]);
        chk("R6 lane0 im", v0i, e.x[1]);
        chk("R6 lane1 re", v1r, e.x[2]);
        chk("R6 lane1 im", v1i, e.x[3]);
        chk("R6 lane2 re", v2r, e.x[4]);
        chk("R6 lane2 im", v2i, e.x[5]);
        chk("R7 inverse sop", out_sop_i, e.sop);
        chk("R7 inverse eop", out_eop_i, e.eop);
      end
    end
    if (in_valid && in_ready) begin
      qf.push_back(model(1'b0));
      qi.push_back(model(1'b1));
      beat_cnt = (beat_cnt + 1) % PKT;
    end
    @(negedge clk);
  endtask

  task automatic set_markers();
    in_sop = (beat_cnt == 0);
    in_eop = (beat_cnt == PKT - 1);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) tick();
  endtask

  task automatic send_one();
    set_markers();
    in_valid = 1'b1;
    out_ready = 1'b1;
    tick();
    drain();
  endtask

  bit done = 0;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 out_valid low after reset", out_valid, 0);
    chk("R1 in_ready high after reset", in_ready, 1);
    @(negedge clk);

    // R2 latency and R4 product rounding: only Y1 contributes to lane 0
    y0r = 0; y0i = 0; y2r = 0; y2i = 0;
    y1r = 16'sd12345; y1i = -16'sd7777; w1r = 16'sd23170; w1i = -16'sd23170;
    w2r = 0; w2i = 0;
    set_markers();
    in_valid = 1'b1; out_ready = 1'b1;
    tick();
    in_valid = 1'b0;
    begin
      int lat = 1;
      while (!out_valid && lat < 10) begin
        tick();
        lat++;
      end
      chk("R2 latency in falling edges", lat, 4);
      #1;
      chk("R4 lane0 re equals rounded product",
          f0r, sat(rnd(longint'(y1r) * w1r - longint'(y1i) * w1i)));
      chk("R4 lane0 im equals rounded product",
          f0i, sat(rnd(longint'(y1r) * w1i + longint'(y1i) * w1r)));
    end
    drain();

    // R10 positive saturation
    y0r = 32767; y0i = 32767; y1r = -32768; y1i = -32768; y2r = -32768; y2i = -32768;
    w1r = -32768; w1i = 0; w2r = -32768; w2i = 0;
    send_one();
    chk("R10 lane0 re clamps high", last_f[0], 32767);
    chk("R10 lane0 im clamps high", last_f[1], 32767);
    // R10 negative saturation
    y0r = -32768; y0i = -32768; w1r = 32767; w2r = 32767;
    send_one();
    chk("R10 lane0 re clamps low", last_f[0], -32768);
    chk("R10 lane0 im clamps low", last_f[1], -32768);

    // constrained random with stalls
    for (int n = 0; n < 3000; n++) begin
      in_valid = ($urandom % 10) < 7;
      out_ready = ($urandom % 10) < 6;
      if ((n % 16) < 3) begin
        y0r = ($urandom % 2) ? 16'sh7fff : 16'sh8000;
        y0i = ($urandom % 2) ? 16'sh7fff : 16'sh8000;
        y1r = 16'sh8000; y1i = r16(); y2r = r16(); y2i = 16'sh8000;
        w1r = 16'sh8000; w1i = r16(); w2r = 16'sh7fff; w2i = r16();
      end else begin
        y0r = r16(); y0i = r16(); y1r = r16(); y1i = r16();
        y2r = r16(); y2i = r16(); w1r = r16(); w1i = r16();
        w2r = r16(); w2i = r16();
      end
      set_markers();
      tick();
    end
    drain();
    chk("R9 forward queue empty", qf.size(), 0);
    chk("R9 inverse queue empty", qi.size(), 0);
    chk("R1 idle after drain", out_valid, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule